// File: doc/BRIEF.md
# Clock-Stop Grant State Controller

This controller sequences a processor's response to a system clock-stop request. Its view of the processor is a small number of signals: per-core halt status, a snoop-detect strobe with a matching completion strobe, a response strobe for acknowledge bus cycles, a processor reset, and four sideband interrupt lines. It tracks five states: Normal, Halt, Entry (the stop has been requested but not yet granted), Stop-Grant and Grant-Snoop.

When the stop request rises, the controller asks for one acknowledge special cycle per die, one die after the other. It waits for the response of each. After the last response it counts a fixed delay and then reports Stop-Grant. The request may be withdrawn only once the grant has been reached. When it is withdrawn, the controller goes back to the state it left, Normal or Halt. While the processor is not in Normal, sideband interrupts are collected, one flag per line. The collected flags are handed out for a single cycle when Normal is entered again.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_ni is low the controller is in Normal (state_o = 0). ack_req_o, irq_valid_o and protocol_err_o are low, and irq_pend_o is zero.
- R2: In Normal, when every core_halt_i bit is high, state_o becomes Halt (1) on the next cycle. In Halt, when any bit is low (and no stop request or snoop is present), state_o becomes Normal (0) on the next cycle.
- R3: A stop_req_i seen in Normal or Halt moves state_o to Entry (2) on the next cycle. ack_req_o is high for exactly one cycle per die. Die 0 is requested first, in the first Entry cycle, and each later die is requested in the cycle after the previous die's response. ack_die_o gives the die index.
- R4: ack_resp_i is counted only when an acknowledge is outstanding, that is, after its request cycle and up to its response. At any other time it has no effect.
- R5: state_o becomes Stop-Grant (3) exactly GRANT_DELAY (default 20) cycles after the cycle in which the last die's response was high.
- R6: If stop_req_i is low during Entry, the controller stays in Entry and protocol_err_o is high in the following cycle.
- R7: stop_req_i low in Stop-Grant, with no snoop present, returns the controller on the next cycle to its origin: Halt if the stop was requested from Halt, otherwise Normal. In Grant-Snoop, removal is deferred until the controller is back in Stop-Grant, and no error is flagged.
- R8: snoop_i in Halt or Stop-Grant moves state_o to Grant-Snoop (4) on the next cycle. snoop_done_i then returns the controller to the state it came from on the following cycle.
- R9: cpu_reset_i in Stop-Grant leaves the controller in Stop-Grant. It clears all pending interrupt flags and sets the origin to Normal, so removal of the request then leads to Normal.
- R10: Interrupt bits are 0 = SMI, 1 = INIT, 2 = local line 0, 3 = local line 1. A high irq_i bit in any state other than Normal sets its pending flag, and repeated pulses collapse into one flag. If any flag is set, the flags appear on irq_pend_o with irq_valid_o high for exactly the first Normal cycle, and are then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | System clock-stop request, active high |
| core_halt_i | input | NUM_CORES | Per-core halted status |
| cpu_reset_i | input | 1 | Processor reset strobe |
| snoop_i | input | 1 | Snoop detected strobe |
| snoop_done_i | input | 1 | Snoop service complete strobe |
| ack_resp_i | input | 1 | Response phase of the outstanding acknowledge cycle |
| irq_i | input | NUM_IRQ | Sideband interrupt lines (SMI, INIT, local 0, local 1) |
| ack_req_o | output | 1 | Request to issue an acknowledge special cycle |
| ack_die_o | output | $clog2(NUM_DIES) | Die index for the acknowledge request |
| state_o | output | 3 | 0 Normal, 1 Halt, 2 Entry, 3 Stop-Grant, 4 Grant-Snoop |
| irq_pend_o | output | NUM_IRQ | Released pending interrupt flags |
| irq_valid_o | output | 1 | irq_pend_o is valid this cycle |
| protocol_err_o | output | 1 | Stop request removed before grant |

## Verification
State changes are due one cycle after the input that causes them. An acknowledge request appears in the first Entry cycle, or one cycle after a response. Stop-Grant is due GRANT_DELAY cycles after the final response, and the error flag one cycle after the illegal removal. Released interrupt flags coincide with the first Normal cycle. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus to the cycle named above and checks there, including the cycle just before the grant. A monitor pops expected acknowledge dies and released interrupt vectors from queues whenever the design strobes them, so a missing, extra or early strobe is reported.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_HALT   = 3'd1,
    ST_ENTRY  = 3'd2,
    ST_GRANT  = 3'd3,
    ST_SNOOP  = 3'd4
  } cs_state_e;

  typedef enum logic [1:0] {
    PH_REQ   = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DELAY = 2'd2,
    PH_DONE  = 2'd3
  } ack_phase_e;

endpackage

// File: rtl/clkstop_ack_seq.sv
module clkstop_ack_seq
  import clkstop_pkg::*;
#(
  parameter int NUM_DIES    = 2,
  parameter int GRANT_DELAY = 20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        active_i,
  input  logic                        ack_resp_i,
  output logic                        ack_req_o,
  output logic [$clog2(NUM_DIES)-1:0] ack_die_o,
  output logic                        done_o
);

  localparam int DIE_W    = $clog2(NUM_DIES);
  localparam int CNT_W    = $clog2(GRANT_DELAY);
  localparam int LAST_CNT = GRANT_DELAY - 2;

  ack_phase_e       phase_q;
  logic [DIE_W-1:0] die_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_die;

  assign last_die = (die_q == DIE_W'(NUM_DIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REQ;
      die_q   <= '0;
      cnt_q   <= '0;
    end else if (!active_i) begin
      phase_q <= PH_REQ;
      die_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_REQ: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (ack_resp_i) begin
            if (last_die) begin
              phase_q <= PH_DELAY;
              cnt_q   <= '0;
            end else begin
              phase_q <= PH_REQ;
              die_q   <= die_q + DIE_W'(1);
            end
          end
        end
        PH_DELAY: begin
          if (cnt_q == CNT_W'(LAST_CNT)) phase_q <= PH_DONE;
          else                           cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign ack_req_o = active_i && (phase_q == PH_REQ);
  assign ack_die_o = die_q;
  assign done_o    = active_i && (phase_q == PH_DELAY) && (cnt_q == CNT_W'(LAST_CNT));

  initial begin
    assert (NUM_DIES >= 2 && GRANT_DELAY >= 2) else $error("bad params");
  end

  // R3: each acknowledge request lasts a single cycle
  p_req_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |=> !ack_req_o);

  // R4: a response during the request cycle does not advance the sequence
  p_resp_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && phase_q == PH_REQ && ack_resp_i) |=> (phase_q == PH_WAIT) && $stable(die_q));

endmodule

// File: rtl/clkstop_irq_latch.sv
module clkstop_irq_latch #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               release_i,
  input  logic               clear_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               valid_o
);

  logic [NUM_IRQ-1:0] pend_q, out_q, pend_next;
  logic               valid_q;

  assign pend_next = pend_q | (capture_i ? irq_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      pend_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (release_i) begin
      pend_q  <= '0;
      out_q   <= pend_next;
      valid_q <= |pend_next;
    end else begin
      pend_q  <= pend_next;
      out_q   <= '0;
      valid_q <= 1'b0;
    end
  end

  assign pend_o  = out_q;
  assign valid_o = valid_q;

  // R10: release is a one-cycle pulse carrying at least one flag, with the store emptied
  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_valid_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (out_q != '0) && (pend_q == '0));
  // R9: processor reset empties the pending store
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pend_q == '0) && !valid_q);

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stop_req_i,
  input  logic      all_halt_i,
  input  logic      snoop_i,
  input  logic      snoop_done_i,
  input  logic      cpu_reset_i,
  input  logic      grant_done_i,
  output cs_state_e state_o,
  output logic      release_o,
  output logic      err_o
);

  cs_state_e state_q, state_d;
  logic      from_halt_q;
  logic      snp_grant_q;
  logic      err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (stop_req_i)      state_d = ST_ENTRY;
        else if (all_halt_i) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (stop_req_i)       state_d = ST_ENTRY;
        else if (snoop_i)     state_d = ST_SNOOP;
        else if (!all_halt_i) state_d = ST_NORMAL;
      end
      ST_ENTRY: begin
        if (grant_done_i) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (snoop_i)          state_d = ST_SNOOP;
        else if (!stop_req_i) state_d = from_halt_q ? ST_HALT : ST_NORMAL;
      end
      ST_SNOOP: begin
        if (snoop_done_i) state_d = snp_grant_q ? ST_GRANT : ST_HALT;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_NORMAL;
      from_halt_q <= 1'b0;
      snp_grant_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_ENTRY) && !stop_req_i;
      if (state_d == ST_ENTRY && state_q != ST_ENTRY)
        from_halt_q <= (state_q == ST_HALT);
      else if (cpu_reset_i && state_q inside {ST_ENTRY, ST_GRANT, ST_SNOOP})
        from_halt_q <= 1'b0;
      if (state_d == ST_SNOOP && state_q != ST_SNOOP)
        snp_grant_q <= (state_q == ST_GRANT);
    end
  end

  assign state_o   = state_q;
  assign release_o = (state_q != ST_NORMAL) && (state_d == ST_NORMAL);
  assign err_o     = err_q;

  // R6: early removal is refused and flagged
  p_early_removal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTRY && !stop_req_i && !grant_done_i) |=> (state_q == ST_ENTRY) && err_o);
  // R7: leaving the grant always lands in Normal or Halt
  p_exit_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && !stop_req_i && !snoop_i) |=> state_q inside {ST_NORMAL, ST_HALT});
  // R7: no exit from snoop service while not done
  p_snoop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SNOOP && !snoop_done_i) |=> state_q == ST_SNOOP);
  // R8: snoop in the grant goes to snoop service
  p_snoop_enter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && snoop_i) |=> state_q == ST_SNOOP);
  // R9: grant held while the request stays up, reset or not
  p_grant_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && stop_req_i) |=> state_q inside {ST_GRANT, ST_SNOOP});
  // R5: the grant is reached only from Entry or snoop service
  p_grant_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && $past(state_q) != ST_GRANT) |-> $past(state_q) inside {ST_ENTRY, ST_SNOOP});

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_DIES    = 2,
  parameter int NUM_IRQ     = 4,
  parameter int GRANT_DELAY = 20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stop_req_i,
  input  logic [NUM_CORES-1:0]        core_halt_i,
  input  logic                        cpu_reset_i,
  input  logic                        snoop_i,
  input  logic                        snoop_done_i,
  input  logic                        ack_resp_i,
  input  logic [NUM_IRQ-1:0]          irq_i,
  output logic                        ack_req_o,
  output logic [$clog2(NUM_DIES)-1:0] ack_die_o,
  output logic [2:0]                  state_o,
  output logic [NUM_IRQ-1:0]          irq_pend_o,
  output logic                        irq_valid_o,
  output logic                        protocol_err_o
);

  cs_state_e state;
  logic      grant_done;
  logic      release_ev;

  clkstop_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_i   (stop_req_i),
    .all_halt_i   (&core_halt_i),
    .snoop_i      (snoop_i),
    .snoop_done_i (snoop_done_i),
    .cpu_reset_i  (cpu_reset_i),
    .grant_done_i (grant_done),
    .state_o      (state),
    .release_o    (release_ev),
    .err_o        (protocol_err_o)
  );

  clkstop_ack_seq #(
    .NUM_DIES    (NUM_DIES),
    .GRANT_DELAY (GRANT_DELAY)
  ) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (state == ST_ENTRY),
    .ack_resp_i (ack_resp_i),
    .ack_req_o  (ack_req_o),
    .ack_die_o  (ack_die_o),
    .done_o     (grant_done)
  );

  clkstop_irq_latch #(
    .NUM_IRQ (NUM_IRQ)
  ) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (state != ST_NORMAL),
    .release_i (release_ev),
    .clear_i   (cpu_reset_i),
    .irq_i     (irq_i),
    .pend_o    (irq_pend_o),
    .valid_o   (irq_valid_o)
  );

  assign state_o = state;

  // R3: acknowledge requests only while entering the grant
  p_req_in_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> state_o == 3'd2);
  // R10: released flags only in Normal
  p_release_normal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> state_o == 3'd0);

endmodule

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;

  localparam int NC = 4;
  localparam int GD = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stop_req_i = 1'b0;
  logic [NC-1:0] core_halt_i = '0;
  logic          cpu_reset_i = 1'b0;
  logic          snoop_i = 1'b0;
  logic          snoop_done_i = 1'b0;
  logic          ack_resp_i = 1'b0;
  logic [3:0]    irq_i = '0;
  logic          ack_req_o;
  logic [0:0]    ack_die_o;
  logic [2:0]    state_o;
  logic [3:0]    irq_pend_o;
  logic          irq_valid_o;
  logic          protocol_err_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int ack_q[$];
  int irq_q[$];

  always #2.5 clk_i = ~clk_i;

  clkstop_ctrl #(.NUM_CORES(NC), .GRANT_DELAY(GD)) dut (
    .clk_i, .rst_ni, .stop_req_i, .core_halt_i, .cpu_reset_i, .snoop_i,
    .snoop_done_i, .ack_resp_i, .irq_i, .ack_req_o, .ack_die_o, .state_o,
    .irq_pend_o, .irq_valid_o, .protocol_err_o
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_state(int exp, string req);
    chk(state_o == 3'(exp), req, "state_o", int'(state_o), exp);
  endtask

  // monitor: pop expected strobes as they appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ack_req_o) begin
        if (ack_q.size() == 0) chk(1'b0, "R3", "unexpected ack_req_o die", int'(ack_die_o), -1);
        else begin
          automatic int e = ack_q.pop_front();
          chk(int'(ack_die_o) == e, "R3", "ack_die_o", int'(ack_die_o), e);
        end
      end
      if (irq_valid_o) begin
        if (irq_q.size() == 0) chk(1'b0, "R10", "unexpected irq release", int'(irq_pend_o), 0);
        else begin
          automatic int e = irq_q.pop_front();
          chk(int'(irq_pend_o) == e, "R10", "irq_pend_o", int'(irq_pend_o), e);
        end
      end
    end
  end

  task automatic resp_pulse();
    ack_resp_i = 1'b1;
    step(1);
    ack_resp_i = 1'b0;
  endtask

  task automatic irq_pulse(logic [3:0] v);
    irq_i = v;
    step(1);
    irq_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    chk_state(0, "R1");
    chk(!ack_req_o && !irq_valid_o && !protocol_err_o && irq_pend_o == 0, "R1",
        "outputs low in reset", int'({ack_req_o, irq_valid_o, protocol_err_o}), 0);
    rst_ni = 1'b1;
    step(1);
    chk_state(0, "R1");

    // R2 halt entry/exit
    core_halt_i = '1; step(1); chk_state(1, "R2");
    core_halt_i = 4'b1110; step(1); chk_state(0, "R2");
    core_halt_i = '1; step(1); chk_state(1, "R2");

    // R3 stop from Halt
    ack_q.push_back(0); ack_q.push_back(1);
    stop_req_i = 1'b1;
    step(1); chk_state(2, "R3");
    chk(ack_req_o == 1'b1, "R3", "die0 request in first Entry cycle", int'(ack_req_o), 1);
    step(2);
    chk(ack_req_o == 1'b0, "R3", "no request while waiting", int'(ack_req_o), 0);
    ack_resp_i = 1'b1;
    step(1);
    chk(ack_req_o == 1'b1, "R3", "die1 request after response", int'(ack_req_o), 1);
    step(1);  // response still high in request cycle: ignored
    ack_resp_i = 1'b0;
    step(30);
    chk_state(2, "R4");
    chk(ack_q.size() == 0, "R3", "two acknowledges issued", ack_q.size(), 0);

    // R6 early removal
    stop_req_i = 1'b0;
    step(1);
    chk(protocol_err_o == 1'b1, "R6", "protocol_err_o", int'(protocol_err_o), 1);
    chk_state(2, "R6");
    stop_req_i = 1'b1;
    step(1);
    chk(protocol_err_o == 1'b0, "R6", "protocol_err_o cleared", int'(protocol_err_o), 0);

    // R10 interrupts collected in Entry, repeats collapse
    irq_pulse(4'b0001); step(1); irq_pulse(4'b0001);

    // R5 grant delay
    resp_pulse();
    step(GD - 2); chk_state(2, "R5");
    step(1);      chk_state(3, "R5");

    irq_pulse(4'b0100);
    // R8 snoop in grant
    snoop_i = 1'b1; step(1); snoop_i = 1'b0;
    chk_state(4, "R8");
    // R7 removal deferred in snoop service
    stop_req_i = 1'b0;
    step(2);
    chk_state(4, "R7");
    chk(protocol_err_o == 1'b0, "R7", "no error on removal in snoop", int'(protocol_err_o), 0);
    snoop_done_i = 1'b1; step(1); snoop_done_i = 1'b0;
    chk_state(3, "R8");
    step(1);
    chk_state(1, "R7");
    chk(irq_valid_o == 1'b0, "R10", "no release in Halt", int'(irq_valid_o), 0);
    irq_q.push_back(5);
    core_halt_i = 4'b0111;
    step(1);
    chk_state(0, "R10");
    chk(irq_valid_o == 1'b1, "R10", "release on first Normal cycle", int'(irq_valid_o), 1);
    step(1);
    chk(irq_valid_o == 1'b0 && irq_pend_o == 0, "R10", "release one cycle", int'(irq_pend_o), 0);

    // R9 reset in grant from Halt origin
    core_halt_i = '1; step(1); chk_state(1, "R2");
    ack_q.push_back(0); ack_q.push_back(1);
    stop_req_i = 1'b1;
    step(2);
    resp_pulse();
    step(1);
    resp_pulse();
    step(GD - 1);
    chk_state(3, "R5");
    irq_pulse(4'b0010);
    cpu_reset_i = 1'b1; step(1); cpu_reset_i = 1'b0;
    chk_state(3, "R9");
    step(3);
    chk_state(3, "R9");
    irq_pulse(4'b1000);
    irq_q.push_back(8);
    stop_req_i = 1'b0;
    step(1);
    chk_state(0, "R9");
    chk(irq_valid_o == 1'b1, "R9", "only post-reset flag released", int'(irq_valid_o), 1);

    // R8 snoop in Halt
    core_halt_i = '1; step(1); chk_state(1, "R2");
    snoop_i = 1'b1; step(1); snoop_i = 1'b0;
    chk_state(4, "R8");
    core_halt_i = '0;
    step(2); chk_state(4, "R8");
    snoop_done_i = 1'b1; step(1); snoop_done_i = 1'b0;
    chk_state(1, "R8");
    step(1);
    chk_state(0, "R2");
    chk(irq_valid_o == 1'b0, "R10", "no release with nothing pending", int'(irq_valid_o), 0);

    step(2);
    chk(ack_q.size() == 0, "R3", "ack queue drained", ack_q.size(), 0);
    chk(irq_q.size() == 0, "R10", "irq queue drained", irq_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule